// File: doc/BRIEF.md
# Time-Multiplexed Programmable FIR Engine

This block is a fixed-point FIR filter built from `P` multiply-accumulate cells. Each cell is reused 1, 2, 4 or 8 times inside one sample period, so the same hardware gives `P`, `2P`, `4P` or `8P` taps. The sample rate falls in proportion. Samples are 16-bit two's complement. Coefficients are written as 16-bit words into internal storage and are rounded toward zero to 12 bits on the way in. Each product is trimmed to a 24-bit fraction before it enters a 32-bit accumulation.

The cells form a transposed chain. In each sample period every cell forms its share of the convolution. It then adds that share to the partial sum left by its upstream neighbour in the previous period. The tail of the chain takes a 32-bit expansion input, so a block further up a cascade can feed its partial result in. A delayed copy of the input stream is available for the next block in a chain. A sample-rate strobe marks each sample boundary.

Computation starts on the first clock edge where the enable is high. A clear input empties every accumulator and the sample history. While the clearing runs, a busy flag is shown.

Top module: `fir_tm_engine`

## Requirements
- R1: `rate_sel` values 0, 1, 2 and 3 set a sample period R of 1, 2, 4 or 8 clocks and a filter length N = P·R. If the start edge is edge 0, sample n is taken from `din` on edge n·R.
- R2: Each written coefficient is rounded toward zero to 12 bits. A non-negative word loses its low 4 bits. A negative word keeps its upper 12 bits plus the OR of its low 4 bits. So 0xFFF1 becomes 0, 0xFFF0 becomes −1 and 0x8000 becomes −2048.
- R3: Each 16×12 product is formed at its full 28 bits. Its 4 low bits are dropped by arithmetic shift. The remaining 24 bits are sign-extended and summed in 32-bit arithmetic.
- R4: Coefficient address t holds the weight of the sample delayed by t periods, so y[n] = Σ_{t<N} c[t]·x[n−t] under R2/R3, with samples before the start taken as zero. y[n] appears on `result` after edge (n+1)·R and holds until the next sample boundary.
- R5: While idle, the first edge with `en` high and `busy` low takes the first sample and realigns the phase counter. An edge with `en` low stops computation.
- R6: `clr_n` sampled low zeroes the accumulators, `result` and the sample history. `busy` is then high for exactly P cycles. An enable seen while `busy` is high does not start the filter.
- R7: `strobe` is high in the last clock of each sample period, which is the cycle before the edge that loads a sample. In rate 0 it is high continuously.
- R8: `exp_in` is added at the tail cell. A constant E on it adds E to y[n] for n ≥ P−1.
- R9: After the load edge of sample n, `dly_out` shows sample n−N, or zero if that sample precedes the start.
- R10: After reset, `result` and `dly_out` are zero, `busy` is low and the filter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Active-low accumulator clear |
| en | input | 1 | Filter enable; the first high edge marks sample 0 |
| rate_sel | input | 2 | Reuse factor select (period 1, 2, 4, 8 clocks) |
| din | input | 16 | Input sample, two's complement |
| exp_in | input | 32 | Expansion partial sum entering the chain tail |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | log2(P)+3 | Coefficient address (tap index) |
| coef_data | input | 16 | Coefficient word, two's complement |
| result | output | 32 | Filter output |
| dly_out | output | 16 | Input stream delayed by N samples |
| strobe | output | 1 | Sample-rate strobe |
| busy | output | 1 | Clear in progress |

## Verification
Take the start edge as edge 0. Sample n is loaded on edge n·R. `dly_out` changes on that same edge. y[n] reaches `result` one period later, on edge (n+1)·R, because the chain registers it once per period. `busy` rises on the edge that samples the clear and falls P edges later. The bench counts edges from the start edge, then checks each output on the falling edge after the edge where that output is due. It also checks that `result` holds its value on the edges inside a period.

// File: rtl/fir_tm_pkg.sv
package fir_tm_pkg;

    localparam int SAMPLE_W  = 16;
    localparam int COEF_IN_W = 16;
    localparam int COEF_W    = 12;
    localparam int DROP_W    = COEF_IN_W - COEF_W;
    localparam int PROD_W    = SAMPLE_W + COEF_W;
    localparam int ACC_W     = 32;
    localparam int MAX_REUSE = 8;
    localparam int PHASE_W   = $clog2(MAX_REUSE);

    typedef logic signed [SAMPLE_W-1:0]  sample_t;
    typedef logic signed [COEF_IN_W-1:0] coef_raw_t;
    typedef logic signed [COEF_W-1:0]    coef_t;
    typedef logic signed [ACC_W-1:0]     acc_t;
    typedef logic [PHASE_W-1:0]          phase_t;

    typedef enum logic [1:0] {
        REUSE_1 = 2'd0,
        REUSE_2 = 2'd1,
        REUSE_4 = 2'd2,
        REUSE_8 = 2'd3
    } reuse_e;

    typedef struct packed {
        logic   run;
        logic   first;
        logic   load;
        phase_t phase;
    } slot_ctl_t;

    // Highest phase index of a sample period for a reuse factor.
    function automatic phase_t last_phase(reuse_e r);
        case (r)
            REUSE_1: return phase_t'(0);
            REUSE_2: return phase_t'(1);
            REUSE_4: return phase_t'(3);
            default: return phase_t'(7);
        endcase
    endfunction

    // 16 -> 12 bit rounding toward zero.
    function automatic coef_t round_to_zero(coef_raw_t c);
        coef_t hi;
        hi = c[COEF_IN_W-1:DROP_W];
        if (c[COEF_IN_W-1])
            return hi + coef_t'(|c[DROP_W-1:0]);
        return hi;
    endfunction

    // Full-width product, low bits dropped, sign-extended to the accumulator.
    function automatic acc_t scaled_product(sample_t x, coef_t c);
        logic signed [PROD_W-1:0] xe;
        logic signed [PROD_W-1:0] ce;
        logic signed [PROD_W-1:0] p;
        xe = PROD_W'(x);
        ce = PROD_W'(c);
        p  = xe * ce;
        return {{(ACC_W-PROD_W+DROP_W){p[PROD_W-1]}}, p[PROD_W-1:DROP_W]};
    endfunction

endpackage

// File: rtl/fir_tm_phase_ctl.sv
module fir_tm_phase_ctl
    import fir_tm_pkg::*;
#(
    parameter int P = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clr_n,
    input  logic      en,
    input  reuse_e    rate,
    output slot_ctl_t ctl,
    output logic      start,
    output logic      shift,
    output logic      strobe,
    output logic      busy
);
    localparam int BW = $clog2(P + 1);

    phase_t        ph_q;
    phase_t        ph_last;
    logic          run_q;
    logic [BW-1:0] busy_q;
    logic          at_end;

    always_comb begin
        ph_last = last_phase(rate);
        at_end  = (ph_q >= ph_last);
        busy    = (busy_q != '0);
        start   = clr_n && !run_q && en && !busy;
        strobe  = at_end;
        ctl.run   = run_q;
        ctl.first = (ph_q == '0);
        ctl.load  = run_q && at_end;
        ctl.phase = ph_q;
        shift     = start || (run_q && at_end);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= '0;
            run_q  <= 1'b0;
            busy_q <= '0;
        end else begin
            if (start || at_end)
                ph_q <= '0;
            else
                ph_q <= ph_q + phase_t'(1);

            if (!clr_n) begin
                run_q  <= 1'b0;
                busy_q <= BW'(P);
            end else begin
                if (busy)
                    busy_q <= busy_q - BW'(1);
                if (start)
                    run_q <= 1'b1;
                else if (!en)
                    run_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/fir_tm_sample_line.sv
module fir_tm_sample_line
    import fir_tm_pkg::*;
#(
    parameter int P = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    shift,
    input  sample_t din,
    input  reuse_e  rate,
    input  phase_t  phase,
    output sample_t tap,
    output sample_t dly_out
);
    localparam int DEPTH = MAX_REUSE * P + 1;

    sample_t hist [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < DEPTH; i++)
                hist[i] <= '0;
        end else if (shift) begin
            hist[0] <= din;
            for (int i = 1; i < DEPTH; i++)
                hist[i] <= hist[i-1];
        end
    end

    // Phase j of a period works on the sample j*P periods old.
    always_comb begin
        tap = hist[0];
        for (int j = 1; j < MAX_REUSE; j++)
            if (phase == phase_t'(j))
                tap = hist[j*P];
    end

    always_comb begin
        case (rate)
            REUSE_1: dly_out = hist[P];
            REUSE_2: dly_out = hist[2*P];
            REUSE_4: dly_out = hist[4*P];
            default: dly_out = hist[8*P];
        endcase
    end

endmodule

// File: rtl/fir_tm_cell.sv
module fir_tm_cell
    import fir_tm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  slot_ctl_t ctl,
    input  logic      wr_en,
    input  phase_t    wr_slot,
    input  coef_raw_t wr_data,
    input  sample_t   tap,
    input  acc_t      base,
    output acc_t      sum_out
);
    coef_t bank [MAX_REUSE];
    acc_t  acc_q;
    acc_t  sum_q;
    acc_t  prod;
    acc_t  acc_next;

    // Rounded once at write time, so reads need no rounding logic.
    always_ff @(posedge clk) begin
        if (wr_en)
            bank[wr_slot] <= round_to_zero(wr_data);
    end

    always_comb begin
        prod     = scaled_product(tap, bank[ctl.phase]);
        acc_next = (ctl.first ? base : acc_q) + prod;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
            sum_q <= '0;
        end else if (ctl.run) begin
            acc_q <= acc_next;
            if (ctl.load)
                sum_q <= acc_next;
        end
    end

    assign sum_out = sum_q;

endmodule

// File: rtl/fir_tm_engine.sv
module fir_tm_engine
    import fir_tm_pkg::*;
#(
    parameter int P = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr_n,
    input  logic                         en,
    input  logic [1:0]                   rate_sel,
    input  logic [15:0]                  din,
    input  logic [31:0]                  exp_in,
    input  logic                         coef_we,
    input  logic [$clog2(P)+2:0]         coef_addr,
    input  logic [15:0]                  coef_data,
    output logic [31:0]                  result,
    output logic [15:0]                  dly_out,
    output logic                         strobe,
    output logic                         busy
);
    localparam int LP = $clog2(P);
    localparam int AW = LP + PHASE_W;

    reuse_e    rate;
    slot_ctl_t ctl;
    logic      start;
    logic      shift;
    logic      run_w;
    sample_t   tap;
    sample_t   dly_s;
    phase_t    wr_slot;
    acc_t      sums [P];

    assign rate    = reuse_e'(rate_sel);
    assign wr_slot = coef_addr[AW-1:LP];
    assign run_w   = ctl.run;

    fir_tm_phase_ctl #(.P(P)) i_ctl (
        .clk    (clk),
        .rst    (rst),
        .clr_n  (clr_n),
        .en     (en),
        .rate   (rate),
        .ctl    (ctl),
        .start  (start),
        .shift  (shift),
        .strobe (strobe),
        .busy   (busy)
    );

    fir_tm_sample_line #(.P(P)) i_line (
        .clk     (clk),
        .rst     (rst),
        .clr     (!clr_n),
        .shift   (shift),
        .din     (sample_t'(din)),
        .rate    (rate),
        .phase   (ctl.phase),
        .tap     (tap),
        .dly_out (dly_s)
    );

    for (genvar k = 0; k < P; k++) begin : g_cell
        acc_t base;
        if (k == P - 1) begin : g_tail
            assign base = acc_t'(exp_in);
        end else begin : g_link
            assign base = sums[k+1];
        end

        fir_tm_cell i_cell (
            .clk     (clk),
            .rst     (rst),
            .clr     (!clr_n),
            .ctl     (ctl),
            .wr_en   (coef_we && (coef_addr[LP-1:0] == LP'(k))),
            .wr_slot (wr_slot),
            .wr_data (coef_raw_t'(coef_data)),
            .tap     (tap),
            .base    (base),
            .sum_out (sums[k])
        );
    end

    assign result  = sums[0];
    assign dly_out = dly_s;

endmodule

// File: rtl/fir_tm_checker.sv
module fir_tm_checker (
    input logic        clk,
    input logic        rst,
    input logic        clr_n,
    input logic        en,
    input logic [1:0]  rate_sel,
    input logic        strobe,
    input logic        busy,
    input logic [31:0] result,
    input logic        run
);

    // R6: the edge that samples a clear raises busy
    a_r6_busy_after_clear: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> busy);

    // R6: the clear empties the output
    a_r6_result_zeroed: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> (result == 32'd0));

    // R5: computation starts only from an enable with no clear pending
    a_r5_start_when_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> ($past(en) && !$past(busy)));

    // R7: full-rate strobe never drops
    a_r7_full_rate_strobe: assert property (@(posedge clk) disable iff (rst)
        (rate_sel == 2'd0) |-> strobe);

    // R4: the output moves only at a sample boundary or a clear
    a_r4_result_on_boundary: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> ($past(strobe && run) || !$past(clr_n)));

endmodule

bind fir_tm_engine fir_tm_checker i_fir_tm_checker (
    .clk      (clk),
    .rst      (rst),
    .clr_n    (clr_n),
    .en       (en),
    .rate_sel (rate_sel),
    .strobe   (strobe),
    .busy     (busy),
    .result   (result),
    .run      (run_w)
);

// File: tb/test_fir_tm_engine.sv
module test_fir_tm_engine;

    localparam int NP = 4;
    localparam int AW = $clog2(NP) + 3;
    localparam int NC = 8 * NP;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr_n = 1'b1;
    logic          en = 1'b0;
    logic [1:0]    rate_sel = 2'd0;
    logic [15:0]   din = '0;
    logic [31:0]   exp_in = '0;
    logic          coef_we = 1'b0;
    logic [AW-1:0] coef_addr = '0;
    logic [15:0]   coef_data = '0;
    logic [31:0]   result;
    logic [15:0]   dly_out;
    logic          strobe;
    logic          busy;

    int checks = 0;
    int fails  = 0;
    int c12 [NC];
    int xs  [160];
    int seed = 32'h1d2c3b4a;

    always #10 clk = ~clk;

    fir_tm_engine #(.P(NP)) i_fir_tm_engine (
        .clk(clk), .rst(rst), .clr_n(clr_n), .en(en), .rate_sel(rate_sel),
        .din(din), .exp_in(exp_in), .coef_we(coef_we), .coef_addr(coef_addr),
        .coef_data(coef_data), .result(result), .dly_out(dly_out),
        .strobe(strobe), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input longint got, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int next_rand();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 9) & 32'hFFFF;
    endfunction

    function automatic int to_s16(int v);
        return int'($signed(16'(v)));
    endfunction

    // Reference convolution: R2 rounding, R3 per-product trim, R8 tail term
    function automatic int ref_y(int m, int taps, int ext);
        int acc = 0;
        for (int t = 0; t < taps; t++)
            if (m - t >= 0)
                acc += (xs[m-t] * c12[t]) >>> 4;
        if (m >= NP - 1)
            acc += ext;
        return acc;
    endfunction

    task automatic pulse_clear();
        int hi;
        @(negedge clk);
        clr_n = 1'b0;
        en    = 1'b0;
        @(negedge clk);
        clr_n = 1'b1;
        check(busy == 1'b1, "R6 busy raised", busy, 1);
        check(result == 32'd0, "R6 result zeroed", $signed(result), 0);
        check(dly_out == 16'd0, "R6 history zeroed", dly_out, 0);
        hi = 1;
        for (int i = 0; i < 3 * NP && busy; i++) begin
            @(negedge clk);
            if (busy) hi++;
        end
        check(hi == NP, "R6 busy length", hi, NP);
    endtask

    task automatic run_mode(input int rate, input int pat, input int ext);
        int r     = 1 << rate;
        int taps  = NP * r;
        int nsamp = taps + 6;
        for (int i = 0; i <= nsamp; i++) begin
            case (pat)
                0: xs[i] = to_s16(next_rand());
                1: xs[i] = (i % 2 == 0) ? 32767 : -32768;
                default: xs[i] = (i == 0) ? 12345 : 0;
            endcase
        end
        pulse_clear();
        rate_sel = 2'(rate);
        exp_in   = 32'(ext);
        repeat (3) @(negedge clk);
        din = 16'(xs[0]);
        en  = 1'b1;
        for (int e = 0; e <= nsamp * r; e++) begin
            @(posedge clk);
            @(negedge clk);
            check(strobe == ((e % r) == r - 1), "R7 strobe phase", strobe, (e % r) == r - 1);
            if (e % r == 0) begin
                int m = e / r;
                int xd = (m - taps >= 0) ? xs[m-taps] : 0;
                check($signed(dly_out) == xd, "R9 delayed sample", $signed(dly_out), xd);
                if (m >= 1)
                    check($signed(result) == ref_y(m - 1, taps, ext),
                          "R1 R2 R3 R4 R8 result", $signed(result), ref_y(m - 1, taps, ext));
            end else if (e >= r) begin
                check($signed(result) == ref_y(e / r - 1, taps, ext),
                      "R4 result hold", $signed(result), ref_y(e / r - 1, taps, ext));
            end
            if ((e + 1) % r == 0)
                din = 16'(xs[(e + 1) / r]);
        end
        en = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(result == 32'd0, "R10 result", $signed(result), 0);
        check(dly_out == 16'd0, "R10 dly_out", dly_out, 0);
        check(busy == 1'b0, "R10 busy", busy, 0);
        check(strobe == 1'b1, "R10 strobe rate0", strobe, 1);

        for (int a = 0; a < NC; a++) begin
            int raw = next_rand();
            case (a)
                0: raw = 16'h8000;
                1: raw = 16'h7FFF;
                2: raw = 16'hFFF1;
                3: raw = 16'hFFF0;
                5: raw = 16'h000F;
                6: raw = 16'hFFEF;
                default: ;
            endcase
            c12[a] = to_s16(raw) / 16;
            coef_we   = 1'b1;
            coef_addr = AW'(a);
            coef_data = 16'(raw);
            @(negedge clk);
        end
        coef_we = 1'b0;

        // R6: enable raised while busy must not start the filter
        @(negedge clk);
        clr_n = 1'b0;
        @(negedge clk);
        clr_n = 1'b1;
        rate_sel = 2'd0;
        din = 16'h4000;
        en = 1'b1;
        repeat (NP - 1) @(negedge clk);
        en = 1'b0;
        repeat (8) @(negedge clk);
        check(result == 32'd0, "R6 enable ignored while busy", $signed(result), 0);

        for (int rt = 0; rt < 4; rt++)
            for (int pt = 0; pt < 3; pt++)
                run_mode(rt, pt, 0);
        run_mode(1, 0, 32'h12345);
        run_mode(3, 1, -77);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule